// File: doc/BRIEF.md
# Block transfer host register window

This block is the host-facing side of a block-transfer management mailbox. A host reaches it through a byte-wide I/O window of four offsets. Offset 0 is a command/status register. Offset 1 is a data port: host writes to it fill an inbound message buffer, and host reads from it drain an outbound message buffer. Offset 2 is handed on unchanged to a separate interrupt block. Offset 3 is unused.

The block keeps three things: the inbound byte count, the outbound read position and length, and the handshake flags. The flags are a host busy bit, a service busy bit and two attention bits. When the host raises its attention bit, the block marks the service side busy and sends it a one-cycle request strobe. The service side then reads the inbound buffer through a private read port. It loads a reply through a write port and a length load, and reports that the reply is ready with a done pulse. Message parsing and interrupt generation are left to neighbouring blocks.

Top module: `bt_host_window`

## Requirements
- R1: Reads return data on `bus_rdata` in the cycle after the `bus_rd` strobe, and that value holds until the next read. `bus_addr` 0 selects the control register, 1 the outbound data, 2 the value of `mask_rdata_i` sampled with the strobe, and 3 the constant 0xFF.
- R2: After a synchronous reset, every flag and pointer is zero. A control read returns 0x00, `in_len_o` is 0, and a data read returns 0xFF.
- R3: A control read packs the flags as follows: bit 3 is the service-to-host attention, bit 4 is the service-event attention, bit 6 is host busy and bit 7 is service busy. Bits 0, 1, 2 and 5 read as zero.
- R4: Writing control with bit 3 or bit 4 set clears that attention flag. A `svc_done` pulse sets bit 3 and clears service busy, and a `svc_sms` pulse sets bit 4. If a set and a clear of the same attention flag arrive in one cycle, the set wins.
- R5: Writing control with bit 6 set inverts the host busy flag.
- R6: Writing control with bit 2 set sets service busy and pulses `req_o` high for exactly the next cycle. This set takes priority over a `svc_done` in the same cycle.
- R7: A data write stores the byte at inbound index `in_len_o` only when that index is below DEPTH. `in_len_o` increases by one on every data write, including writes past DEPTH. `svc_in_data` shows the byte at `svc_in_addr` one cycle later.
- R8: Writing control with bit 0 set returns `in_len_o` to zero.
- R9: A data read returns the outbound byte at the read position and advances the position. Consuming the last byte returns both position and length to zero. A data read with nothing pending returns 0xFF.
- R10: Writing control with bit 1 set returns the outbound read position to zero, so the next data read returns byte 0 again.
- R11: `svc_out_we` writes `svc_out_data` into the outbound buffer at `svc_out_addr`. `svc_out_len_we` loads the outbound length from `svc_out_len` and restarts the read position at zero.
- R12: A write to offset 2 appears one cycle later as a one-cycle `mask_wr_o` carrying the written byte on `mask_wdata_o`, and it changes no control flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid the cycle after `bus_rd` |
| mask_wr_o | output | 1 | Write strobe forwarded to the interrupt block |
| mask_wdata_o | output | 8 | Byte forwarded with `mask_wr_o` |
| mask_rdata_i | input | 8 | Interrupt mask value returned on offset-2 reads |
| req_o | output | 1 | One-cycle request-ready strobe to the service side |
| b2h_atn_o | output | 1 | Service-to-host attention flag |
| sms_atn_o | output | 1 | Service-event attention flag |
| svc_done | input | 1 | Reply ready: set attention, clear service busy |
| svc_sms | input | 1 | Raise the service-event attention |
| in_len_o | output | LEN_W | Inbound write count |
| svc_in_addr | input | AW | Inbound buffer read address |
| svc_in_data | output | 8 | Inbound buffer byte, one cycle after the address |
| svc_out_we | input | 1 | Outbound buffer byte write enable |
| svc_out_addr | input | AW | Outbound buffer write address |
| svc_out_data | input | 8 | Outbound buffer write byte |
| svc_out_len_we | input | 1 | Outbound length load enable |
| svc_out_len | input | LEN_W | Outbound length, at most DEPTH |

## Verification
The assertions assume that the host never issues `bus_rd` and `bus_wr` in the same cycle. They also assume that a loaded outbound length never exceeds DEPTH and that `svc_out_len_we` never coincides with a host data read. The pointer bound and the drain behaviour rely on these conditions. The stimulus issues each host access as an isolated single-cycle strobe and only loads reply lengths of 3 with the host idle. Its one deliberate collision is a `svc_done` pulse landing on a host attention-clear write, which is legal and exercises the set-wins rule.

// File: rtl/bt_win_pkg.sv
package bt_win_pkg;

  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_DATA = 2'd1,
    OFS_MASK = 2'd2,
    OFS_NONE = 2'd3
  } bt_ofs_e;

  // control register bit positions (host-visible, decoded by software)
  localparam int unsigned CB_CLR_WR = 0;
  localparam int unsigned CB_CLR_RD = 1;
  localparam int unsigned CB_H2B    = 2;
  localparam int unsigned CB_B2H    = 3;
  localparam int unsigned CB_SMS    = 4;
  localparam int unsigned CB_HBUSY  = 6;
  localparam int unsigned CB_BBUSY  = 7;

  localparam logic [7:0] CMD_BITS  = 8'hDF;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

endpackage

// File: rtl/bt_win_ctrl.sv
module bt_win_ctrl
  import bt_win_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       svc_done,
  input  logic       svc_sms,
  output logic [7:0] ctrl_byte,
  output logic       clr_wr,
  output logic       clr_rd,
  output logic       req_o,
  output logic       b2h_o,
  output logic       sms_o
);

  logic [7:0] cmd;
  logic hbusy_q, bbusy_q, b2h_q, sms_q, req_q;

  assign cmd    = wr_en ? (wdata & CMD_BITS) : 8'h00;
  assign clr_wr = cmd[CB_CLR_WR];
  assign clr_rd = cmd[CB_CLR_RD];

  always_ff @(posedge clk) begin
    if (rst) begin
      hbusy_q <= 1'b0;
      bbusy_q <= 1'b0;
      b2h_q   <= 1'b0;
      sms_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= cmd[CB_H2B];
      if (cmd[CB_HBUSY]) hbusy_q <= ~hbusy_q;
      if (cmd[CB_H2B])   bbusy_q <= 1'b1;
      else if (svc_done) bbusy_q <= 1'b0;
      if (svc_done)      b2h_q <= 1'b1;
      else if (cmd[CB_B2H]) b2h_q <= 1'b0;
      if (svc_sms)       sms_q <= 1'b1;
      else if (cmd[CB_SMS]) sms_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_byte           = 8'h00;
    ctrl_byte[CB_B2H]   = b2h_q;
    ctrl_byte[CB_SMS]   = sms_q;
    ctrl_byte[CB_HBUSY] = hbusy_q;
    ctrl_byte[CB_BBUSY] = bbusy_q;
  end

  assign req_o = req_q;
  assign b2h_o = b2h_q;
  assign sms_o = sms_q;

  // R6: a request strobe always coincides with service busy
  assert_req_busy_R6: assert property (@(posedge clk) disable iff (rst)
    req_q |-> bbusy_q);

  // R5: toggle command inverts host busy
  assert_hbusy_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[CB_HBUSY]) |=> (hbusy_q != $past(hbusy_q)));

  // R4: reply-ready pulse always leaves the attention flag raised
  assert_done_sets_atn_R4: assert property (@(posedge clk) disable iff (rst)
    svc_done |=> b2h_q);

endmodule

// File: rtl/bt_win_inbuf.sv
module bt_win_inbuf #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LEN_W = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  input  logic             clr,
  input  logic [AW-1:0]    svc_addr,
  output logic [LEN_W-1:0] len,
  output logic [7:0]       svc_data
);

  logic [7:0]       mem [DEPTH];
  logic [LEN_W-1:0] len_q;
  logic [7:0]       rd_q;
  logic             fits;

  assign fits = len_q < LEN_W'(DEPTH);

  // simple dual-port memory: host write port, service read port
  always_ff @(posedge clk) begin
    if (wr_en && fits) mem[len_q[AW-1:0]] <= wdata;
    rd_q <= mem[svc_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)        len_q <= '0;
    else if (clr)   len_q <= '0;
    else if (wr_en) len_q <= len_q + LEN_W'(1);
  end

  assign len      = len_q;
  assign svc_data = rd_q;

  // R7: every data write counts, in range or not
  assert_len_step_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> (len_q == $past(len_q) + LEN_W'(1)));

  // R8: clear command empties the inbound count
  assert_clr_wr_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (len_q == '0));

endmodule

// File: rtl/bt_win_outbuf.sv
module bt_win_outbuf
  import bt_win_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LEN_W = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             clr_rd,
  input  logic             ld_we,
  input  logic [AW-1:0]    ld_addr,
  input  logic [7:0]       ld_data,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_val,
  output logic [7:0]       rd_byte
);

  logic [7:0]       mem [DEPTH];
  logic [LEN_W-1:0] pos_q, len_q;
  logic [7:0]       dout_q;
  logic             empty_q;
  logic             avail;

  assign avail = pos_q < len_q;

  // simple dual-port memory: service write port, host read port
  always_ff @(posedge clk) begin
    if (ld_we) mem[ld_addr] <= ld_data;
    if (rd_en) dout_q <= mem[pos_q[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      len_q   <= '0;
      empty_q <= 1'b1;
    end else begin
      if (rd_en) empty_q <= ~avail;
      if (len_we) begin
        len_q <= len_val;
        pos_q <= '0;
      end else if (rd_en && avail) begin
        if (pos_q + LEN_W'(1) == len_q) begin
          pos_q <= '0;
          len_q <= '0;
        end else begin
          pos_q <= pos_q + LEN_W'(1);
        end
      end else if (clr_rd) begin
        pos_q <= '0;
      end
    end
  end

  assign rd_byte = empty_q ? IDLE_BYTE : dout_q;

  // R9: position stays inside the pending message, or rests at zero
  assert_pos_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (pos_q < len_q) || (pos_q == '0));

  // R10: rewind command returns the read position to zero
  assert_rewind_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_rd && !len_we) |=> (pos_q == '0));

  // R11: a length load restarts the read position
  assert_len_load_R11: assert property (@(posedge clk) disable iff (rst)
    len_we |=> (pos_q == '0 && len_q == $past(len_val)));

endmodule

// File: rtl/bt_host_window.sv
module bt_host_window
  import bt_win_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LEN_W = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             mask_wr_o,
  output logic [7:0]       mask_wdata_o,
  input  logic [7:0]       mask_rdata_i,
  output logic             req_o,
  output logic             b2h_atn_o,
  output logic             sms_atn_o,
  input  logic             svc_done,
  input  logic             svc_sms,
  output logic [LEN_W-1:0] in_len_o,
  input  logic [AW-1:0]    svc_in_addr,
  output logic [7:0]       svc_in_data,
  input  logic             svc_out_we,
  input  logic [AW-1:0]    svc_out_addr,
  input  logic [7:0]       svc_out_data,
  input  logic             svc_out_len_we,
  input  logic [LEN_W-1:0] svc_out_len
);

  logic       wr_ctrl, wr_data, wr_mask, rd_data;
  logic [7:0] ctrl_byte, out_byte;
  logic       clr_wr, clr_rd;
  bt_ofs_e    sel_q;
  logic [7:0] ctrl_snap_q, mask_snap_q;
  logic       mask_wr_q;
  logic [7:0] mask_wdata_q;

  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign wr_mask = bus_wr && (bus_addr == OFS_MASK);
  assign rd_data = bus_rd && (bus_addr == OFS_DATA);

  bt_win_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_ctrl),
    .wdata     (bus_wdata),
    .svc_done  (svc_done),
    .svc_sms   (svc_sms),
    .ctrl_byte (ctrl_byte),
    .clr_wr    (clr_wr),
    .clr_rd    (clr_rd),
    .req_o     (req_o),
    .b2h_o     (b2h_atn_o),
    .sms_o     (sms_atn_o)
  );

  bt_win_inbuf #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_inbuf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_data),
    .wdata    (bus_wdata),
    .clr      (clr_wr),
    .svc_addr (svc_in_addr),
    .len      (in_len_o),
    .svc_data (svc_in_data)
  );

  bt_win_outbuf #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_outbuf (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_data),
    .clr_rd  (clr_rd),
    .ld_we   (svc_out_we),
    .ld_addr (svc_out_addr),
    .ld_data (svc_out_data),
    .len_we  (svc_out_len_we),
    .len_val (svc_out_len),
    .rd_byte (out_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q        <= OFS_NONE;
      ctrl_snap_q  <= 8'h00;
      mask_snap_q  <= 8'h00;
      mask_wr_q    <= 1'b0;
      mask_wdata_q <= 8'h00;
    end else begin
      mask_wr_q <= wr_mask;
      if (wr_mask) mask_wdata_q <= bus_wdata;
      if (bus_rd) begin
        sel_q       <= bt_ofs_e'(bus_addr);
        ctrl_snap_q <= ctrl_byte;
        mask_snap_q <= mask_rdata_i;
      end
    end
  end

  always_comb begin
    case (sel_q)
      OFS_CTRL: bus_rdata = ctrl_snap_q;
      OFS_DATA: bus_rdata = out_byte;
      OFS_MASK: bus_rdata = mask_snap_q;
      default:  bus_rdata = IDLE_BYTE;
    endcase
  end

  assign mask_wr_o    = mask_wr_q;
  assign mask_wdata_o = mask_wdata_q;

  // R1: the unused offset reads as all ones
  assert_unmapped_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd3) |=> (bus_rdata == 8'hFF));

  // R12: mask writes are forwarded one cycle later with their byte
  assert_mask_fwd_R12: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> (mask_wr_o && mask_wdata_o == $past(bus_wdata)));

  // R1: host strobes are exclusive
  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

endmodule

// File: tb/bt_host_window_tb.sv
module bt_host_window_tb;

  localparam int unsigned DEPTH = 64;
  localparam int unsigned LEN_W = 8;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int          NVEC  = 15;

  // {req[23:20], rd[19], 0[18], addr[17:16], wdata[15:8], expect[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h280000,  // R2 control reads zero after reset
    24'h2900FF,  // R2 data read with nothing pending
    24'h1B00FF,  // R1 offset 3 reads 0xFF
    24'h504000,  // R5 toggle host busy
    24'h580040,  // R5 R3 host busy at bit 6
    24'h504000,  // R5 toggle back
    24'h580000,  // R5 cleared
    24'h600400,  // R6 host attention
    24'h680080,  // R6 R3 service busy at bit 7
    24'h504400,  // R5 toggle with attention in one write
    24'h5800C0,  // R5 both busy bits
    24'h504000,  // R5 toggle back
    24'h580080,  // R5 service busy remains
    24'h1A005A,  // R1 offset 2 returns interrupt-block value
    24'h280080   // R3 unchanged on re-read
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]       bus_addr = 2'd0;
  logic [7:0]       bus_wdata = 8'h00;
  logic [7:0]       bus_rdata;
  logic             mask_wr_o;
  logic [7:0]       mask_wdata_o;
  logic [7:0]       mask_rdata_i = 8'h5A;
  logic             req_o, b2h_atn_o, sms_atn_o;
  logic             svc_done = 1'b0, svc_sms = 1'b0;
  logic [LEN_W-1:0] in_len_o;
  logic [AW-1:0]    svc_in_addr = '0;
  logic [7:0]       svc_in_data;
  logic             svc_out_we = 1'b0;
  logic [AW-1:0]    svc_out_addr = '0;
  logic [7:0]       svc_out_data = 8'h00;
  logic             svc_out_len_we = 1'b0;
  logic [LEN_W-1:0] svc_out_len = '0;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  bt_host_window #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic in_peek(input int idx, output logic [7:0] d);
    @(negedge clk);
    svc_in_addr = AW'(idx);
    @(negedge clk);
    d = svc_in_data;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][19]) begin
        host_rd(VEC[i][17:16], r);
        n_checks++;
        if (r !== VEC[i][7:0]) begin
          n_fail++;
          $display("FAIL vec %0d R%0d: got %0h expected %0h", i, VEC[i][23:20], r, VEC[i][7:0]);
        end
      end else begin
        host_wr(VEC[i][17:16], VEC[i][15:8]);
      end
    end

    // R6 request strobe lasts exactly one cycle
    host_wr(2'd0, 8'h04);
    check("R6 req high", 32'(req_o), 32'd1);
    @(negedge clk);
    check("R6 req low", 32'(req_o), 32'd0);

    // R4 reply ready, event attention, clears
    svc_done = 1'b1;
    @(negedge clk);
    svc_done = 1'b0;
    check("R4 b2h flag", 32'(b2h_atn_o), 32'd1);
    host_rd(2'd0, r);
    check("R4 R3 ctrl after done", 32'(r), 32'h08);
    svc_sms = 1'b1;
    @(negedge clk);
    svc_sms = 1'b0;
    host_rd(2'd0, r);
    check("R4 ctrl after sms", 32'(r), 32'h18);
    host_wr(2'd0, 8'h08);
    host_rd(2'd0, r);
    check("R4 clear b2h", 32'(r), 32'h10);
    host_wr(2'd0, 8'h10);
    host_rd(2'd0, r);
    check("R4 clear sms", 32'(r), 32'h00);

    // R4 set wins over a same-cycle clear
    @(negedge clk);
    svc_done = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h08;
    @(negedge clk);
    svc_done = 1'b0; bus_wr = 1'b0;
    host_rd(2'd0, r);
    check("R4 set wins", 32'(r), 32'h08);
    host_wr(2'd0, 8'h08);

    // R7 inbound fill past capacity
    for (int i = 0; i < DEPTH + 2; i++) host_wr(2'd1, 8'(i) ^ 8'hA5);
    check("R7 count past capacity", 32'(in_len_o), 32'(DEPTH + 2));
    in_peek(0, r);
    check("R7 first byte", 32'(r), 32'hA5);
    in_peek(DEPTH - 1, r);
    check("R7 last stored byte", 32'(r), 32'(8'(DEPTH - 1) ^ 8'hA5));

    // R8 clear write pointer
    host_wr(2'd0, 8'h01);
    check("R8 count cleared", 32'(in_len_o), 32'd0);
    host_wr(2'd1, 8'h3C);
    in_peek(0, r);
    check("R8 R7 restart at 0", 32'(r), 32'h3C);
    check("R8 R7 count one", 32'(in_len_o), 32'd1);

    // R11 load outbound reply
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      svc_out_we = 1'b1; svc_out_addr = AW'(i); svc_out_data = 8'(8'h11 * (i + 1));
    end
    @(negedge clk);
    svc_out_we = 1'b0; svc_out_len_we = 1'b1; svc_out_len = LEN_W'(3);
    @(negedge clk);
    svc_out_len_we = 1'b0;

    // R9 R10 drain, rewind, drain fully
    host_rd(2'd1, r);
    check("R9 R11 byte 0", 32'(r), 32'h11);
    host_rd(2'd1, r);
    check("R9 byte 1", 32'(r), 32'h22);
    host_wr(2'd0, 8'h02);
    host_rd(2'd1, r);
    check("R10 rewound byte 0", 32'(r), 32'h11);
    host_rd(2'd1, r);
    check("R10 byte 1", 32'(r), 32'h22);
    host_rd(2'd1, r);
    check("R9 last byte", 32'(r), 32'h33);
    host_rd(2'd1, r);
    check("R9 drained reads FF", 32'(r), 32'hFF);
    host_wr(2'd0, 8'h02);
    host_rd(2'd1, r);
    check("R9 length zeroed after drain", 32'(r), 32'hFF);

    // R12 mask forwarding
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h81;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R12 mask strobe", 32'(mask_wr_o), 32'd1);
    check("R12 mask byte", 32'(mask_wdata_o), 32'h81);
    @(negedge clk);
    check("R12 strobe one cycle", 32'(mask_wr_o), 32'd0);
    host_rd(2'd0, r);
    check("R12 ctrl untouched", 32'(r), 32'h00);

    // R2 reset from a busy state
    host_wr(2'd0, 8'h44);
    host_wr(2'd1, 8'h77);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R2 req after reset", 32'(req_o), 32'd0);
    check("R2 count after reset", 32'(in_len_o), 32'd0);
    host_rd(2'd0, r);
    check("R2 ctrl after reset", 32'(r), 32'h00);
    host_rd(2'd1, r);
    check("R2 data after reset", 32'(r), 32'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule